// File: doc/BRIEF.md
# State Tour Sequence Monitor

This block watches the 3-bit state code of a neighbouring finite state machine and recognises four fixed walks ("tours") through its states. Some steps of a tour must appear exactly once, and others may repeat for one or more cycles. When a tour completes, the block raises a one-cycle pulse for that tour. It also keeps a saturating hit count per tour and sets a sticky flag once two particular tours have each completed at least once.

A second function measures how long the watched machine stays in one chosen state (code 2 by default). When the machine leaves that state, the block presents the number of extra cycles it stayed there, together with a one-cycle valid strobe. The block is intended to sit beside a controller in silicon as a live coverage and sequence monitor. It observes the state code only, and the state code is sampled only on the rising clock edge.

Top module: `tour_watch`

## Requirements
- R1: While `rst` is high at a rising edge, every tour tracker, hit counter, the combined flag and the dwell logic clear. After that edge, all outputs read 0.
- R2: Tour A (bit 0 of `match_o`) is code 0 one or more times, then 1, 2 and 3 exactly once each, then 0. The pulse is high for the one cycle after the edge that samples the first closing 0. Further 0s do not raise it again.
- R3: Tour B (bit 1) is 0 one or more times, then 1, then 2 two or more times. It pulses once, in the cycle after the edge that samples the second consecutive 2. Further 2s do not re-trigger it.
- R4: Tour C (bit 2) is 0+, 1, 2+, 0. It pulses in the cycle after the first closing 0 is sampled.
- R5: Tour D (bit 3) is 0+, 4, 3+, 0. It pulses in the cycle after the first closing 0 is sampled.
- R6: A code that does not fit the next expected step abandons the partial tour. If that code is 0, it is taken as the first step of a new attempt, and the closing 0 of a completed tour can also open the next one.
- R7: `hits_o` holds one HIT_W-bit counter per tour, with tour t at bits [t*HIT_W +: HIT_W]. Each counter increases by one at the edge after its tour's pulse and stops at its all-ones value.
- R8: `both_o` rises at the edge after the later of the first tour C pulse and the first tour D pulse. It then stays high until reset.
- R9: Entering the dwell state starts a count at 0, and each further consecutive cycle in that state adds one. At the first edge that samples another code, `dwell_cnt_o` takes the count and `dwell_vld_o` is high for that one cycle.
- R10: The dwell count stops at its all-ones value. `dwell_cnt_o` keeps its value until the next exit from the dwell state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| state_i | input | STATE_W | State code of the watched machine |
| match_o | output | 4 | One-cycle tour completion pulses, bit t for tour t (A,B,C,D) |
| hits_o | output | 4*HIT_W | Saturating completion counters, tour t at [t*HIT_W +: HIT_W] |
| both_o | output | 1 | Sticky: tours C and D have each completed |
| dwell_cnt_o | output | DWELL_W | Extra cycles of the last stay in the dwell state |
| dwell_vld_o | output | 1 | One-cycle strobe when a new dwell count is presented |

## Verification
The bench builds the block with HIT_W = 3 and DWELL_W = 3, which keeps STATE_W = 3 and the dwell code at 2. The narrow counters reach their all-ones limit after seven tour completions or a stay of eight cycles in state 2, so saturation and hold behaviour can be checked within a short run. A reference model keeps the full history of sampled codes. On every clock it decides tour completion by matching patterns backwards over that history, and it compares every output against the result.

// File: rtl/tw_pkg.sv
package tw_pkg;

   localparam int NTOUR = 4;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_M1,
      PH_M2,
      PH_M3
   } tw_phase_e;

   // tour table: index 0 = A, 1 = B, 2 = C, 3 = D
   function automatic int tour_mid1(input int t);
      return (t == 3) ? 4 : 1;
   endfunction

   function automatic int tour_mid2(input int t);
      return (t == 3) ? 3 : 2;
   endfunction

   function automatic int tour_mid2_min(input int t);
      return (t == 1) ? 2 : 1;
   endfunction

   function automatic int tour_mid2_rep(input int t);
      return (t == 0) ? 0 : 1;
   endfunction

   function automatic int tour_has_mid3(input int t);
      return (t == 0) ? 1 : 0;
   endfunction

   function automatic int tour_has_tail(input int t);
      return (t == 1) ? 0 : 1;
   endfunction

endpackage

// File: rtl/tw_tour_match.sv
module tw_tour_match #(
   parameter int STATE_W  = 3,
   parameter int LEAD     = 0,
   parameter int MID1     = 1,
   parameter int MID2     = 2,
   parameter int MID2_MIN = 1,
   parameter int MID2_REP = 0,
   parameter int HAS_MID3 = 0,
   parameter int MID3     = 3,
   parameter int HAS_TAIL = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [STATE_W-1:0] code_i,
   output logic               hit_o
);
   import tw_pkg::*;

   localparam logic [STATE_W-1:0] C_LEAD = STATE_W'(LEAD);
   localparam logic [STATE_W-1:0] C_MID1 = STATE_W'(MID1);
   localparam logic [STATE_W-1:0] C_MID2 = STATE_W'(MID2);
   localparam logic [STATE_W-1:0] C_MID3 = STATE_W'(MID3);
   localparam logic [1:0]         C_MIN  = 2'(MID2_MIN);
   localparam bit                 ENDS_ON_MID2 = (HAS_MID3 == 0) && (HAS_TAIL == 0);

   if (MID2_MIN < 1 || MID2_MIN > 3) begin : g_bad_min
      $error("tw_tour_match: MID2_MIN must be 1..3");
   end
   if (MID2_REP == 0 && MID2_MIN != 1) begin : g_bad_rep
      $error("tw_tour_match: a non-repeating step needs MID2_MIN of 1");
   end
   if (HAS_MID3 != 0 && HAS_TAIL == 0) begin : g_bad_tail
      $error("tw_tour_match: a third middle step needs a closing run");
   end
   if (MID1 == LEAD || MID2 == LEAD || MID2 == MID1) begin : g_bad_codes
      $error("tw_tour_match: step codes must differ from their neighbours");
   end

   tw_phase_e  ph_q, ph_d;
   tw_phase_e  restart;
   logic [1:0] rep_q, rep_d, rep_inc;
   logic       hit_d;
   logic       reached;

   assign restart = (code_i == C_LEAD) ? PH_LEAD : PH_IDLE;
   assign rep_inc = (rep_q == 2'd3) ? 2'd3 : rep_q + 2'd1;
   assign reached = (rep_q >= C_MIN);

   always_comb begin
      ph_d  = restart;
      rep_d = rep_q;
      hit_d = 1'b0;
      unique case (ph_q)
         PH_IDLE: ph_d = restart;
         PH_LEAD: begin
            if (code_i == C_MID1) ph_d = PH_M1;
         end
         PH_M1: begin
            if (code_i == C_MID2) begin
               ph_d  = PH_M2;
               rep_d = 2'd1;
               hit_d = ENDS_ON_MID2 && (C_MIN == 2'd1);
            end
         end
         PH_M2: begin
            if (code_i == C_MID2) begin
               if (MID2_REP != 0) begin
                  ph_d  = PH_M2;
                  rep_d = rep_inc;
                  hit_d = ENDS_ON_MID2 && (rep_inc == C_MIN) && (rep_q < C_MIN);
               end
            end else if (HAS_MID3 != 0) begin
               if (code_i == C_MID3 && reached) ph_d = PH_M3;
            end else if (HAS_TAIL != 0) begin
               if (code_i == C_LEAD && reached) hit_d = 1'b1;
            end
         end
         PH_M3: begin
            if (code_i == C_LEAD) hit_d = 1'b1;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= PH_IDLE;
         rep_q <= 2'd0;
         hit_o <= 1'b0;
      end else begin
         ph_q  <= ph_d;
         rep_q <= rep_d;
         hit_o <= hit_d;
      end
   end

endmodule

// File: rtl/tw_sat_count.sv
module tw_sat_count #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   if (W < 1) begin : g_bad_w
      $error("tw_sat_count: W must be at least 1");
   end

   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (rst)                        cnt_o <= '0;
      else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + W'(1);
   end

endmodule

// File: rtl/tw_dwell.sv
module tw_dwell #(
   parameter int STATE_W = 3,
   parameter int W       = 16,
   parameter int CODE    = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [STATE_W-1:0] code_i,
   output logic [W-1:0]       cnt_o,
   output logic               vld_o
);
   if (W < 1) begin : g_bad_w
      $error("tw_dwell: W must be at least 1");
   end

   localparam logic [STATE_W-1:0] C_CODE = STATE_W'(CODE);
   localparam logic [W-1:0]       TOP    = '1;

   logic         in_run;
   logic [W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_run <= 1'b0;
         run_q  <= '0;
         cnt_o  <= '0;
         vld_o  <= 1'b0;
      end else if (code_i == C_CODE) begin
         in_run <= 1'b1;
         vld_o  <= 1'b0;
         if (!in_run)          run_q <= '0;
         else if (run_q != TOP) run_q <= run_q + W'(1);
      end else begin
         in_run <= 1'b0;
         vld_o  <= in_run;
         if (in_run) cnt_o <= run_q;
      end
   end

endmodule

// File: rtl/tour_watch.sv
module tour_watch #(
   parameter int STATE_W    = 3,
   parameter int HIT_W      = 16,
   parameter int DWELL_W    = 16,
   parameter int DWELL_CODE = 2
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [STATE_W-1:0]             state_i,
   output logic [tw_pkg::NTOUR-1:0]       match_o,
   output logic [tw_pkg::NTOUR*HIT_W-1:0] hits_o,
   output logic                           both_o,
   output logic [DWELL_W-1:0]             dwell_cnt_o,
   output logic                           dwell_vld_o
);
   import tw_pkg::*;

   localparam int IDX_C = 2;
   localparam int IDX_D = 3;

   if (STATE_W < 3) begin : g_bad_state_w
      $error("tour_watch: STATE_W must hold code 4");
   end
   if (DWELL_CODE < 0 || DWELL_CODE >= (1 << STATE_W)) begin : g_bad_dwell
      $error("tour_watch: DWELL_CODE out of range");
   end

   for (genvar t = 0; t < NTOUR; t++) begin : g_tour
      tw_tour_match #(
         .STATE_W  (STATE_W),
         .LEAD     (0),
         .MID1     (tour_mid1(t)),
         .MID2     (tour_mid2(t)),
         .MID2_MIN (tour_mid2_min(t)),
         .MID2_REP (tour_mid2_rep(t)),
         .HAS_MID3 (tour_has_mid3(t)),
         .MID3     (3),
         .HAS_TAIL (tour_has_tail(t))
      ) match_i (
         .clk    (clk),
         .rst    (rst),
         .code_i (state_i),
         .hit_o  (match_o[t])
      );

      tw_sat_count #(.W(HIT_W)) hits_i (
         .clk   (clk),
         .rst   (rst),
         .inc_i (match_o[t]),
         .cnt_o (hits_o[t*HIT_W +: HIT_W])
      );
   end

   logic seen_c, seen_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_c <= 1'b0;
         seen_d <= 1'b0;
      end else begin
         seen_c <= seen_c | match_o[IDX_C];
         seen_d <= seen_d | match_o[IDX_D];
      end
   end

   assign both_o = seen_c & seen_d;

   tw_dwell #(
      .STATE_W (STATE_W),
      .W       (DWELL_W),
      .CODE    (DWELL_CODE)
   ) dwell_i (
      .clk    (clk),
      .rst    (rst),
      .code_i (state_i),
      .cnt_o  (dwell_cnt_o),
      .vld_o  (dwell_vld_o)
   );

endmodule

// File: rtl/tw_watch_chk.sv
module tw_watch_chk #(
   parameter int STATE_W    = 3,
   parameter int HIT_W      = 16,
   parameter int DWELL_W    = 16,
   parameter int DWELL_CODE = 2
) (
   input logic                           clk,
   input logic                           rst,
   input logic [STATE_W-1:0]             state_i,
   input logic [tw_pkg::NTOUR-1:0]       match_o,
   input logic [tw_pkg::NTOUR*HIT_W-1:0] hits_o,
   input logic                           both_o,
   input logic [DWELL_W-1:0]             dwell_cnt_o,
   input logic                           dwell_vld_o
);
   localparam logic [STATE_W-1:0] C_DW = STATE_W'(DWELL_CODE);

   for (genvar t = 0; t < tw_pkg::NTOUR; t++) begin : g_t
      // R2
      single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
         match_o[t] |=> !match_o[t]);
      // R7
      hit_step_chk: assert property (@(posedge clk) disable iff (rst)
         !$stable(hits_o[t*HIT_W +: HIT_W]) |-> ($past(match_o[t]) || $past(rst)));
   end

   // R3
   tour_b_close_chk: assert property (@(posedge clk) disable iff (rst)
      match_o[1] |-> ($past(state_i) == STATE_W'(2)));

   // R4
   tour_c_close_chk: assert property (@(posedge clk) disable iff (rst)
      match_o[2] |-> ($past(state_i) == '0));

   // R5
   tour_d_close_chk: assert property (@(posedge clk) disable iff (rst)
      match_o[3] |-> ($past(state_i) == '0));

   // R8
   both_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      both_o |=> both_o);

   // R9
   dwell_exit_chk: assert property (@(posedge clk) disable iff (rst)
      dwell_vld_o |-> ($past(state_i) != C_DW));

   // R10
   dwell_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(dwell_cnt_o) |-> (dwell_vld_o || $past(rst)));

endmodule

bind tour_watch tw_watch_chk #(
   .STATE_W    (STATE_W),
   .HIT_W      (HIT_W),
   .DWELL_W    (DWELL_W),
   .DWELL_CODE (DWELL_CODE)
) chk_i (.*);

// File: tb/tour_watch_tb_top.sv
module tour_watch_tb_top;
   localparam int HW   = 3;
   localparam int DW   = 3;
   localparam int NT   = 4;
   localparam int HMAX = (1 << HW) - 1;
   localparam int DMAX = (1 << DW) - 1;

   logic           clk = 1'b0;
   logic           rst;
   logic [2:0]     state_i;
   logic [NT-1:0]  match_o;
   logic [NT*HW-1:0] hits_o;
   logic           both_o;
   logic [DW-1:0]  dwell_cnt_o;
   logic           dwell_vld_o;

   always #10 clk = ~clk;

   tour_watch #(.STATE_W(3), .HIT_W(HW), .DWELL_W(DW), .DWELL_CODE(2)) dut_i (
      .clk(clk), .rst(rst), .state_i(state_i), .match_o(match_o),
      .hits_o(hits_o), .both_o(both_o), .dwell_cnt_o(dwell_cnt_o),
      .dwell_vld_o(dwell_vld_o)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference model state
   int hist[$];
   bit exp_m[NT];
   int exp_h[NT];
   bit seen_c, seen_d, exp_both;
   bit in_run, exp_vld;
   int run_len, exp_cnt;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int h_at(input int back);
      int n = hist.size();
      return (n - 1 - back >= 0) ? hist[n - 1 - back] : -1;
   endfunction

   // x+ m1 m2+ 0 ending at the newest sample
   function automatic bit plus_tour(input int m1, input int m2);
      int i = 1;
      if (h_at(0) != 0 || h_at(1) != m2) return 0;
      while (h_at(i) == m2) i++;
      return (h_at(i) == m1) && (h_at(i + 1) == 0);
   endfunction

   task automatic model_clear();
      hist.delete();
      foreach (exp_m[t]) begin exp_m[t] = 0; exp_h[t] = 0; end
      seen_c = 0; seen_d = 0; exp_both = 0;
      in_run = 0; exp_vld = 0; run_len = 0; exp_cnt = 0;
   endtask

   task automatic model_step(input int code);
      foreach (exp_m[t]) if (exp_m[t] && exp_h[t] < HMAX) exp_h[t]++;
      if (exp_m[2]) seen_c = 1;
      if (exp_m[3]) seen_d = 1;
      exp_both = seen_c && seen_d;
      hist.push_back(code);
      exp_m[0] = (h_at(0) == 0 && h_at(1) == 3 && h_at(2) == 2 && h_at(3) == 1 && h_at(4) == 0);
      exp_m[1] = (h_at(0) == 2 && h_at(1) == 2 && h_at(2) == 1 && h_at(3) == 0);
      exp_m[2] = plus_tour(1, 2);
      exp_m[3] = plus_tour(4, 3);
      if (code == 2) begin
         if (!in_run) run_len = 0;
         else if (run_len < DMAX) run_len++;
         in_run = 1;
         exp_vld = 0;
      end else begin
         exp_vld = in_run;
         if (in_run) exp_cnt = run_len;
         in_run = 0;
      end
   endtask

   task automatic compare_all();
      check(match_o[0] == exp_m[0], "R2 tour A pulse", match_o[0], exp_m[0]);
      check(match_o[1] == exp_m[1], "R3 tour B pulse", match_o[1], exp_m[1]);
      check(match_o[2] == exp_m[2], "R4 tour C pulse", match_o[2], exp_m[2]);
      check(match_o[3] == exp_m[3], "R5 tour D pulse", match_o[3], exp_m[3]);
      for (int t = 0; t < NT; t++)
         check(int'(hits_o[t*HW +: HW]) == exp_h[t], "R7 hit counter",
               int'(hits_o[t*HW +: HW]), exp_h[t]);
      check(both_o == exp_both, "R8 combined flag", both_o, exp_both);
      check(dwell_vld_o == exp_vld, "R9 dwell strobe", dwell_vld_o, exp_vld);
      check(int'(dwell_cnt_o) == exp_cnt, "R10 dwell value", int'(dwell_cnt_o), exp_cnt);
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic cyc(input int code);
      state_i = 3'(code);
      @(posedge clk);
      if (rst) model_clear();
      else     model_step(code);
      @(negedge clk);
      compare_all();
   endtask

   task automatic seq(input int codes[$]);
      foreach (codes[i]) cyc(codes[i]);
   endtask

   task automatic do_reset();
      rst = 1;
      cyc(0);
      cyc(0);
      rst = 0;
      // R1
      check(match_o == '0 && hits_o == '0 && !both_o && dwell_cnt_o == '0 && !dwell_vld_o,
            "R1 reset state", int'(hits_o), 0);
   endtask

   initial begin
      rst = 1;
      state_i = 0;
      model_clear();
      @(negedge clk);
      do_reset();

      // R2: held zeros after completion must not re-trigger
      seq('{0, 0, 1, 2, 3, 0, 0, 0, 5});
      // R3: long run of 2 fires once; dwell count on exit (R9)
      seq('{0, 1, 2, 2, 2, 2, 5, 6});
      // R4
      seq('{0, 0, 1, 2, 2, 2, 0, 0});
      // R5 then R8
      seq('{0, 4, 3, 3, 0, 0, 6});
      check(both_o == 1'b1, "R8 both after C and D", both_o, 1);

      // R6: repeated 2 breaks tour A; stray code breaks all
      seq('{0, 1, 2, 2, 3, 0, 7});
      check(match_o[0] == 1'b0 && exp_h[0] == int'(hits_o[0 +: HW]), "R6 tour A aborted",
            match_o[0], 0);
      seq('{0, 1, 7, 2, 0, 1, 0, 1, 2, 3, 0});
      check(match_o[0] == 1'b1, "R6 restart on 0 then tour A", match_o[0], 1);
      // closing 0 doubles as the next lead
      seq('{1, 2, 0, 1, 2, 0});

      // R7: tour C saturation
      for (int k = 0; k < 10; k++) seq('{0, 1, 2, 0});
      check(int'(hits_o[2*HW +: HW]) == HMAX, "R7 tour C saturated",
            int'(hits_o[2*HW +: HW]), HMAX);

      // R10: long stay in 2 saturates, then held
      cyc(0);
      for (int k = 0; k < 12; k++) cyc(2);
      seq('{1, 5, 6, 4});
      check(int'(dwell_cnt_o) == DMAX, "R10 dwell saturated held", int'(dwell_cnt_o), DMAX);
      // short stay of three cycles
      seq('{2, 2, 2, 3});
      seq('{2, 0});

      // R1: reset in the middle of a tour
      seq('{0, 1, 2});
      do_reset();
      seq('{2, 0, 1, 2, 3, 0});

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule